// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block turns twelve external request pins into twelve sticky request flags and presents them as a 16-bit status register. Each line has its own two-bit detection setting, which can be low level, falling edge, rising edge or any edge. Once a flag is set, it stays set until something removes it. Software can remove it through a guarded write of 0. The exception handler can remove it through an acknowledge. The data transfer controller can remove it through its own acknowledge.

A flag can be cleared by software only after a register read has returned that flag as 1. The block keeps a per-line "seen set" latch for this purpose. Every read reloads all twelve latches with the current flag values. A write of 0 to a bit clears that flag only when its latch holds 1, and the write also empties the latch. A handler that never reads the register therefore cannot discard a request it has not observed.

The flags are also driven out as a pending vector for a downstream priority encoder. Input synchronisation, masking, priority and vector generation are done elsewhere.

Top module: `irqf_top`

## Requirements
- R1: Register reads return flag n at bit n for n = 0..11. Bits 15..12 always read 0, and written values to those bits have no effect.
- R2: After reset every flag is 0 and the read data is 0.
- R3: The sense field of line n is `sense_i[2n+1:2n]`, encoded as 00 = low level, 01 = falling edge, 10 = rising edge, 11 = both edges. An edge is the pin differing from its value one cycle earlier. When the selected condition holds at a clock edge, the flag is 1 after that edge.
- R4: Writing 1 to a flag bit has no effect. Writing 0 clears the flag only if the most recent read returned that bit as 1. Each read reloads the per-bit latch, and a clearing write empties it.
- R5: In edge modes (01, 10, 11), an exception acknowledge for line n clears flag n.
- R6: In low-level mode (00), an exception acknowledge clears flag n only if the pin is 1 in that cycle. While the pin is 0, the flag stays set.
- R7: A transfer-controller acknowledge for line n clears flag n when `dtc_keep_i[n]` is 0. When `dtc_keep_i[n]` is 1, the acknowledge leaves the flag unchanged.
- R8: If a set condition and any clear fall in the same cycle, the flag is 1 afterwards.
- R9: `pending_o` always equals read-data bits 11..0.
- R10: Changing a line's sense field while its pin is steady does not set the flag. No edge is seen in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 12 | Synchronised request pins, line n at bit n |
| sense_i | input | 24 | Two sense bits per line (encoding in R3) |
| rd_en_i | input | 1 | Register read strobe; loads the seen-set latches |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; 0 bits request a clear |
| rd_data_o | output | 16 | Status register read value |
| exc_ack_i | input | 12 | Exception-handling acknowledge pulse per line |
| dtc_ack_i | input | 12 | Transfer-controller acknowledge pulse per line |
| dtc_keep_i | input | 12 | Per-line disable-select bit of the triggering transfer |
| pending_o | output | 12 | Flags, for the priority encoder |

## Verification
The hazardous overlap in this block is a new set condition in the same cycle as a clear. The clear can come from an exception acknowledge or from a qualified software write of 0. The bench provokes both cases. It raises a rising-mode pin in the same cycle as the handler acknowledge. It toggles an any-edge pin in the same cycle as a guarded write of 0, which also legitimately clears a neighbouring flag. The bench expects the new request to survive while the neighbour clears. A second overlap is a low-level acknowledge arriving while the pin is still low; the bench expects that flag to remain.

// File: rtl/irqf_pkg.sv
// Package: shared types for the external interrupt request flag unit.
// Assumes two sense bits per line, with encoding fixed by the requirements.
package irqf_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    // True when the mode reacts to transitions rather than to a level.
    function automatic logic is_edge_mode(input sense_e m);
        return (m != SENSE_LOW);
    endfunction

endpackage

// File: rtl/irqf_edge_detect.sv
// Module: per-line condition detector.
// Compares each pin with its previous-cycle sample and applies the line's
// selected sense mode. Assumes pins are already synchronous to clk.
// No edge is reported until one sample has been taken after reset.
module irqf_edge_detect
    import irqf_pkg::*;
#(
    parameter int NUM_LINES = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES-1:0]     pin_i,
    input  logic [2*NUM_LINES-1:0]   sense_i,
    output logic [NUM_LINES-1:0]     set_o,
    output logic [NUM_LINES-1:0]     edge_mode_o
);

    logic [NUM_LINES-1:0] pin_q;
    logic                 primed;

    // Keep last-cycle pin sample and mark when it becomes valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            primed <= 1'b0;
        end else begin
            pin_q  <= pin_i;
            primed <= 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        sense_e mode;
        logic   rise;
        logic   fall;

        assign mode = sense_e'(sense_i[2*g +: 2]);
        assign rise = primed & ~pin_q[g] &  pin_i[g];
        assign fall = primed &  pin_q[g] & ~pin_i[g];
        assign edge_mode_o[g] = is_edge_mode(mode);

        // Select the set condition for this line from its mode.
        always_comb begin
            unique case (mode)
                SENSE_LOW:  set_o[g] = ~pin_i[g];
                SENSE_FALL: set_o[g] = fall;
                SENSE_RISE: set_o[g] = rise;
                SENSE_BOTH: set_o[g] = rise | fall;
                default:    set_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/irqf_regif.sv
// Module: status register access decode.
// Forms the 16-bit read value, with reserved bits returning 0. Turns a write
// into per-line "clear requested" strobes; ones in the data are ignored.
// Assumes read and write strobes last one cycle each.
module irqf_regif #(
    parameter int NUM_LINES = 12,
    parameter int REG_W     = 16
) (
    input  logic [NUM_LINES-1:0] flags_i,
    input  logic                 wr_en_i,
    input  logic [REG_W-1:0]     wr_data_i,
    output logic [REG_W-1:0]     rd_data_o,
    output logic [NUM_LINES-1:0] wr_zero_o
);

    localparam int RSV_W = REG_W - NUM_LINES;

    logic unused_rsv;

    // Reserved write bits are accepted and discarded.
    assign unused_rsv = ^wr_data_i[REG_W-1:NUM_LINES];

    // Read value: flags in the low bits, reserved field forced to 0.
    assign rd_data_o = {{RSV_W{1'b0}}, flags_i};

    // A clear is requested only where the written bit is 0.
    assign wr_zero_o = {NUM_LINES{wr_en_i}} & ~wr_data_i[NUM_LINES-1:0];

endmodule

// File: rtl/irqf_flag_cell.sv
// Module: one request flag with its read-before-clear latch.
// Set has priority over every clear source so that no request is lost.
// The seen latch is reloaded on every read. A write clear uses the latch
// value from before that cycle's read.
module irqf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic edge_mode_i,
    input  logic pin_i,
    input  logic exc_ack_i,
    input  logic dtc_ack_i,
    input  logic dtc_keep_i,
    input  logic rd_i,
    input  logic wr_zero_i,
    output logic flag_o
);

    logic seen_q;
    logic sw_clr;
    logic exc_clr;
    logic dtc_clr;

    assign sw_clr  = wr_zero_i & seen_q;
    assign exc_clr = exc_ack_i & (edge_mode_i | pin_i);
    assign dtc_clr = dtc_ack_i & ~dtc_keep_i;

    // Flag register: set wins, otherwise any qualified clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (sw_clr | exc_clr | dtc_clr) begin
            flag_o <= 1'b0;
        end
    end

    // Seen-set latch: loaded by reads, emptied by a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (rd_i) begin
            seen_q <= flag_o;
        end else if (sw_clr) begin
            seen_q <= 1'b0;
        end
    end

endmodule

// File: rtl/irqf_top.sv
// Module: external interrupt request flag unit, top level.
// Combines the per-line condition detectors, the register decode and one
// flag cell per line. The flags drive both the read data and pending_o.
// Assumes synchronous pins and single-cycle strobes and acknowledges.
module irqf_top #(
    parameter int NUM_LINES = 12,
    parameter int REG_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   pin_i,
    input  logic [2*NUM_LINES-1:0] sense_i,
    input  logic                   rd_en_i,
    input  logic                   wr_en_i,
    input  logic [REG_W-1:0]       wr_data_i,
    output logic [REG_W-1:0]       rd_data_o,
    input  logic [NUM_LINES-1:0]   exc_ack_i,
    input  logic [NUM_LINES-1:0]   dtc_ack_i,
    input  logic [NUM_LINES-1:0]   dtc_keep_i,
    output logic [NUM_LINES-1:0]   pending_o
);

    logic [NUM_LINES-1:0] set_req;
    logic [NUM_LINES-1:0] edge_mode;
    logic [NUM_LINES-1:0] wr_zero;
    logic [NUM_LINES-1:0] flags;

    irqf_edge_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .sense_i     (sense_i),
        .set_o       (set_req),
        .edge_mode_o (edge_mode)
    );

    irqf_regif #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_regif (
        .flags_i   (flags),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .wr_zero_o (wr_zero)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cell
        irqf_flag_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (set_req[g]),
            .edge_mode_i (edge_mode[g]),
            .pin_i       (pin_i[g]),
            .exc_ack_i   (exc_ack_i[g]),
            .dtc_ack_i   (dtc_ack_i[g]),
            .dtc_keep_i  (dtc_keep_i[g]),
            .rd_i        (rd_en_i),
            .wr_zero_i   (wr_zero[g]),
            .flag_o      (flags[g])
        );
    end

    assign pending_o = flags;

endmodule

// File: rtl/irqf_checker.sv
// Module: assertion checker for irqf_top, attached by bind.
// Keeps its own pin history and read history so that its properties do not
// reuse the design's internal state.
module irqf_checker #(
    parameter int NUM_LINES = 12,
    parameter int REG_W     = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LINES-1:0]   pin_i,
    input logic [2*NUM_LINES-1:0] sense_i,
    input logic                   rd_en_i,
    input logic                   wr_en_i,
    input logic [REG_W-1:0]       wr_data_i,
    input logic [REG_W-1:0]       rd_data_o,
    input logic [NUM_LINES-1:0]   exc_ack_i,
    input logic [NUM_LINES-1:0]   dtc_ack_i,
    input logic [NUM_LINES-1:0]   dtc_keep_i,
    input logic [NUM_LINES-1:0]   pending_o
);

    logic [NUM_LINES-1:0] pin_h;
    logic                 hist_ok;
    logic                 any_rd;

    // Independent pin history and "a read has happened" tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_h   <= '0;
            hist_ok <= 1'b0;
            any_rd  <= 1'b0;
        end else begin
            pin_h   <= pin_i;
            hist_ok <= 1'b1;
            any_rd  <= any_rd | rd_en_i;
        end
    end

    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o >> NUM_LINES) == '0);

    assert_pending_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o == rd_data_o[NUM_LINES-1:0]);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        // R4 R5 R7: a flag only drops after one of its clear sources.
        assert_fall_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pending_o[g]) |->
                $past(exc_ack_i[g] || (dtc_ack_i[g] && !dtc_keep_i[g]) ||
                      (wr_en_i && !wr_data_i[g])));

        assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (exc_ack_i[g] && sense_i[2*g +: 2] == 2'b00 && !pin_i[g] && pending_o[g])
                |=> pending_o[g]);

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hist_ok && sense_i[2*g +: 2] == 2'b10 && !pin_h[g] && pin_i[g])
                |=> pending_o[g]);

        assert_no_blind_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_rd && !rd_en_i && pending_o[g] && !exc_ack_i[g] &&
             !(dtc_ack_i[g] && !dtc_keep_i[g])) |=> pending_o[g]);
    end

endmodule

bind irqf_top irqf_checker #(.NUM_LINES(NUM_LINES), .REG_W(REG_W)) u_irqf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin_i),
    .sense_i    (sense_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .exc_ack_i  (exc_ack_i),
    .dtc_ack_i  (dtc_ack_i),
    .dtc_keep_i (dtc_keep_i),
    .pending_o  (pending_o)
);

// File: tb/tb_irqf_top.sv
`timescale 1ns/1ps
// Directed bench for irqf_top: one task per scenario, each checking itself.
module tb_irqf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pin_i = '0;
    logic [23:0] sense_i = 24'hAAAAAA;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic [11:0] exc_ack_i = '0;
    logic [11:0] dtc_ack_i = '0;
    logic [11:0] dtc_keep_i = '0;
    logic [11:0] pending_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    irqf_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .sense_i    (sense_i),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .exc_ack_i  (exc_ack_i),
        .dtc_ack_i  (dtc_ack_i),
        .dtc_keep_i (dtc_keep_i),
        .pending_o  (pending_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] exp);
        n_tests++;
        if (rd_data_o !== exp || {4'h0, pending_o} !== exp) begin
            n_fail++;
            $display("FAIL %s rd_data=%h pending=%h expected=%h", req, rd_data_o, pending_o, exp);
        end
    endtask

    task automatic set_sense(input int line, input logic [1:0] m);
        sense_i[2*line +: 2] = m;
    endtask

    task automatic do_read();
        rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en_i = 1'b1; wr_data_i = d; tick(); wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic t_reset();
        tick();
        chk("R2 reset", 16'h0000);
    endtask

    task automatic t_rise();
        pin_i[0] = 1'b1; tick();
        chk("R3 rising sets line 0", 16'h0001);
    endtask

    task automatic t_write_ignored();
        do_write(16'hFFFF);
        chk("R4 R1 write ones ignored", 16'h0001);
        do_write(16'h0000);
        chk("R4 write 0 without read", 16'h0001);
    endtask

    task automatic t_read_clear();
        do_read();
        do_write(16'h0000);
        chk("R4 read then write 0 clears", 16'h0000);
    endtask

    task automatic t_stale_read();
        do_read();
        pin_i[1] = 1'b1; tick();
        chk("R3 rising line 1", 16'h0002);
        do_write(16'h0000);
        chk("R4 stale read no clear", 16'h0002);
        do_read();
        do_write(16'h0002);
        chk("R4 write 1 keeps flag", 16'h0002);
        do_write(16'h0000);
        chk("R4 latch survives write of 1", 16'h0000);
    endtask

    task automatic t_fall();
        set_sense(2, 2'b01);
        pin_i[2] = 1'b1; tick();
        chk("R3 falling ignores rise", 16'h0000);
        pin_i[2] = 1'b0; tick();
        chk("R3 falling sets", 16'h0004);
        exc_ack_i[2] = 1'b1; tick(); exc_ack_i[2] = 1'b0;
        chk("R5 ack clears edge flag", 16'h0000);
    endtask

    task automatic t_both();
        set_sense(3, 2'b11);
        pin_i[3] = 1'b1; tick();
        chk("R3 both-edge rise", 16'h0008);
        exc_ack_i[3] = 1'b1; tick(); exc_ack_i[3] = 1'b0;
        chk("R5 ack clears both-edge", 16'h0000);
        pin_i[3] = 1'b0; tick();
        chk("R3 both-edge fall", 16'h0008);
        exc_ack_i[3] = 1'b1; tick(); exc_ack_i[3] = 1'b0;
        chk("R5 second ack", 16'h0000);
    endtask

    task automatic t_level();
        set_sense(4, 2'b00); pin_i[4] = 1'b1; tick();
        chk("R10 level mode pin high", 16'h0000);
        pin_i[4] = 1'b0; tick();
        chk("R3 low level sets", 16'h0010);
        exc_ack_i[4] = 1'b1; tick(); exc_ack_i[4] = 1'b0;
        chk("R6 ack with pin low keeps", 16'h0010);
        pin_i[4] = 1'b1; tick();
        chk("R6 flag held after pin high", 16'h0010);
        exc_ack_i[4] = 1'b1; tick(); exc_ack_i[4] = 1'b0;
        chk("R6 ack with pin high clears", 16'h0000);
    endtask

    task automatic t_dtc();
        pin_i[5] = 1'b1; tick();
        chk("R3 rising line 5", 16'h0020);
        dtc_ack_i[5] = 1'b1; dtc_keep_i[5] = 1'b1; tick();
        chk("R7 keep=1 leaves flag", 16'h0020);
        dtc_keep_i[5] = 1'b0; tick(); dtc_ack_i[5] = 1'b0;
        chk("R7 keep=0 clears", 16'h0000);
    endtask

    task automatic t_collide();
        pin_i[6] = 1'b1; tick();
        pin_i[6] = 1'b0; tick();
        chk("R3 rising line 6 held", 16'h0040);
        exc_ack_i[6] = 1'b1; pin_i[6] = 1'b1; tick(); exc_ack_i[6] = 1'b0;
        chk("R8 set beats ack", 16'h0040);
        set_sense(7, 2'b11);
        pin_i[7] = 1'b1; tick();
        chk("R3 line 7 set", 16'h00C0);
        do_read();
        pin_i[7] = 1'b0;
        do_write(16'h0000);
        chk("R8 set beats write clear", 16'h0080);
        do_read();
        do_write(16'h0000);
        chk("R4 clear after collision", 16'h0000);
    endtask

    task automatic t_mode_change();
        pin_i[8] = 1'b1; tick();
        chk("R3 rising line 8", 16'h0100);
        exc_ack_i[8] = 1'b1; tick(); exc_ack_i[8] = 1'b0;
        set_sense(8, 2'b01); tick();
        chk("R10 switch to falling", 16'h0000);
        set_sense(8, 2'b11); tick();
        chk("R10 switch to both", 16'h0000);
        set_sense(8, 2'b10); tick();
        chk("R10 switch to rising", 16'h0000);
    endtask

    task automatic t_top_line();
        pin_i[11] = 1'b1; tick();
        chk("R1 line 11 at bit 11", 16'h0800);
        do_read();
        do_write(16'hF000);
        chk("R1 R4 reserved ones, flag clears", 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rise();
        t_write_ignored();
        t_read_clear();
        t_stale_read();
        t_fall();
        t_both();
        t_level();
        t_dtc();
        t_collide();
        t_mode_change();
        t_top_line();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule